// File: doc/BRIEF.md
# PLL Bring-Up Sequencer

This block starts a clock-multiplying PLL by stepping through its two control registers in a fixed order. A one-cycle start pulse samples the multiplier and pre-divider inputs. The sequencer then forces the PLL output into bypass and holds the PLL in reset. It writes the multiplier and pre-divider fields and programs a 12-bit loop-bandwidth value derived from the multiplier. It waits out the reset time, releases reset, waits a lock time that grows with the pre-divider, and finally takes the output out of bypass.

Each change to a register is a read followed by a write to the same address. The write keeps every bit outside the targeted field at the value just read, so reserved bits survive. The register bus carries one transfer at a time, and the master holds each request until the slave answers with ready. The reset time is a parameter counted in reference-clock cycles, and the lock time is 500 × (pre-divider + 1) cycles. A busy flag covers the whole run, and a done pulse marks its end.

Top module: `pll_bringup_seq`

## Requirements
- R1: After reset, `busy`, `done` and `bus_req` are all 0, and they stay 0 until a start pulse arrives.
- R2: A start pulse seen while idle causes seven read-modify-write steps. Their register addresses are, in order: A, B, A, A, B, B, A, where A = `CTL_A_ADDR` and B = `CTL_B_ADDR`. Each step is a read (`bus_we`=0) followed by a write (`bus_we`=1) to the same address.
- R3: While `bus_req` is high and `bus_ready` is low, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` hold their values into the next cycle.
- R4: Each write equals the data just read, except for the bits of the field that step targets.
- R5: The first three steps do the following, in order. They set the bypass bit A[23], then set the PLL-reset bit B[14]. They then load the multiplier into A[18:6] and the pre-divider into A[5:0].
- R6: The bandwidth value is ((M + 1) >> 1) − 1, taken modulo 4096, where M is the multiplier. Step 4 writes bits [7:0] of it into A[31:24], and step 5 writes bits [11:8] of it into B[3:0]. M = 0 gives 0xFFF.
- R7: Between the write handshake of step 5 and the read request of step 6, `bus_req` stays low for exactly `RST_WAIT_CYC` + 3 cycles.
- R8: Step 6 clears the PLL-reset bit B[14].
- R9: Between the write handshake of step 6 and the read request of step 7, `bus_req` stays low for exactly `LOCK_UNIT` × (D + 1) + 3 cycles, where D is the pre-divider.
- R10: Step 7 clears the bypass bit A[23]. After that, no further bus request is made.
- R11: `done` is high for exactly one cycle, two cycles after the final write handshake. `busy` falls in that same cycle, and `busy` rises in the cycle after the accepted start.
- R12: A start pulse that arrives while `busy` is high is ignored. The multiplier and pre-divider used for the whole run are the values sampled at the accepted start.
- R13: Between the write handshake of one step and the read request of the next step, where neither wait applies, `bus_req` is low for exactly 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin bring-up |
| mult_in | input | 13 | Feedback multiplier value |
| div_in | input | 6 | Reference pre-divider value |
| busy | output | 1 | High while a bring-up run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| bus_req | output | 1 | Register-bus request, held until ready |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with ready |
| bus_ready | input | 1 | Slave completion handshake |

## Verification
The hardest cases to reach from the ports are a start pulse that lands in the middle of a run, and the two timed waits measured to the exact cycle while the slave's ready latency varies.
The bench models the two registers with random reserved bits and answers each request after a random delay. It counts the cycles in which `bus_req` is low between steps, and checks every write against the read value and the field rules. On several runs it fires a second start, carrying a different multiplier and pre-divider, partway through the sequence. It then checks that the writes still carry the first run's values and that only one `done` appears.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int MULT_W   = 13;
  localparam int DIV_W    = 6;
  localparam int BW_W     = 12;
  localparam int DATA_W   = 32;
  localparam int STEP_W   = 3;

  // field placement inside the two control registers
  localparam int BYP_BIT  = 23;  // register A
  localparam int RST_BIT  = 14;  // register B
  localparam int MULT_LSB = 6;   // register A
  localparam int DIV_LSB  = 0;   // register A
  localparam int BWLO_LSB = 24;  // register A, 8 bits
  localparam int BWHI_LSB = 0;   // register B, 4 bits

  // step numbers whose completion starts a timed wait, and the final step
  localparam logic [STEP_W-1:0] STEP_BWHI = 3'd4;
  localparam logic [STEP_W-1:0] STEP_RREL = 3'd5;
  localparam logic [STEP_W-1:0] STEP_LAST = 3'd6;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_AWAIT, S_WAIT} seq_state_t;

  function automatic logic [BW_W-1:0] bw_calc(input logic [MULT_W-1:0] m);
    logic [MULT_W:0] t;
    t = {1'b0, m} + 1'b1;
    return BW_W'((t >> 1) - 1'b1);
  endfunction
endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (load) begin
        cnt <= load_val;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) expired <= 1'b1;
      end
    end
  end

  // R7
  load_len_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(load_val)) && !expired);
endmodule

// File: rtl/pll_seq_steps.sv
module pll_seq_steps
  import pll_seq_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  input  logic [MULT_W-1:0] mult,
  input  logic [DIV_W-1:0]  div,
  output logic              sel_b,
  output logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] setv
);
  logic [BW_W-1:0] bw;
  assign bw = bw_calc(mult);

  always_comb begin
    sel_b = 1'b0;
    mask  = '0;
    setv  = '0;
    case (step)
      3'd0: begin mask = DATA_W'(1) << BYP_BIT; setv = mask; end
      3'd1: begin sel_b = 1'b1; mask = DATA_W'(1) << RST_BIT; setv = mask; end
      3'd2: begin
        mask = (DATA_W'({MULT_W{1'b1}}) << MULT_LSB) | (DATA_W'({DIV_W{1'b1}}) << DIV_LSB);
        setv = (DATA_W'(mult) << MULT_LSB) | (DATA_W'(div) << DIV_LSB);
      end
      3'd3: begin mask = DATA_W'(8'hFF) << BWLO_LSB; setv = DATA_W'(bw[7:0]) << BWLO_LSB; end
      3'd4: begin sel_b = 1'b1; mask = DATA_W'(4'hF) << BWHI_LSB; setv = DATA_W'(bw[11:8]) << BWHI_LSB; end
      3'd5: begin sel_b = 1'b1; mask = DATA_W'(1) << RST_BIT; end
      3'd6: begin mask = DATA_W'(1) << BYP_BIT; end
      default: ;
    endcase
  end
endmodule

// File: rtl/pll_seq_rmw.sv
module pll_seq_rmw #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] setv,
  output logic              op_done,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ready
);
  typedef enum logic [1:0] {E_IDLE, E_RD, E_WR} eng_t;
  eng_t              st;
  logic [DATA_W-1:0] mask_q, setv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= E_IDLE;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      mask_q    <= '0;
      setv_q    <= '0;
      op_done   <= 1'b0;
    end else begin
      op_done <= 1'b0;
      case (st)
        E_IDLE: if (go) begin
          bus_req  <= 1'b1;
          bus_we   <= 1'b0;
          bus_addr <= addr_in;
          mask_q   <= mask;
          setv_q   <= setv;
          st       <= E_RD;
        end
        E_RD: if (bus_ready) begin
          bus_we    <= 1'b1;
          bus_wdata <= (bus_rdata & ~mask_q) | (setv_q & mask_q);
          st        <= E_WR;
        end
        E_WR: if (bus_ready) begin
          bus_req <= 1'b0;
          bus_we  <= 1'b0;
          op_done <= 1'b1;
          st      <= E_IDLE;
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ready) |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  // R2
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we && bus_ready) |=> bus_req && bus_we && $stable(bus_addr));
endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq
  import pll_seq_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter logic [ADDR_W-1:0] CTL_A_ADDR = 8'h00,
  parameter logic [ADDR_W-1:0] CTL_B_ADDR = 8'h04,
  parameter int RST_WAIT_CYC = 250,
  parameter int LOCK_UNIT    = 500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [MULT_W-1:0] mult_in,
  input  logic [DIV_W-1:0]  div_in,
  output logic              busy,
  output logic              done,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ready
);
  localparam int LOCK_MAX = LOCK_UNIT * (1 << DIV_W);
  localparam int CNT_MAX  = (RST_WAIT_CYC > LOCK_MAX) ? RST_WAIT_CYC : LOCK_MAX;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  seq_state_t        state;
  logic [STEP_W-1:0] step;
  logic [MULT_W-1:0] mult_q;
  logic [DIV_W-1:0]  div_q;

  logic              go, op_done, sel_b, tmr_load, tmr_exp;
  logic [DATA_W-1:0] mask, setv;
  logic [CNT_W-1:0]  tmr_val, lock_len;

  assign go       = (state == S_ISSUE);
  assign lock_len = CNT_W'(LOCK_UNIT * (int'(div_q) + 1));
  assign tmr_load = (state == S_AWAIT) && op_done && ((step == STEP_BWHI) || (step == STEP_RREL));
  assign tmr_val  = (step == STEP_BWHI) ? CNT_W'(RST_WAIT_CYC) : lock_len;

  pll_seq_steps u_steps (
    .step(step), .mult(mult_q), .div(div_q),
    .sel_b(sel_b), .mask(mask), .setv(setv)
  );

  pll_seq_rmw #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rmw (
    .clk(clk), .rst(rst), .go(go),
    .addr_in(sel_b ? CTL_B_ADDR : CTL_A_ADDR),
    .mask(mask), .setv(setv), .op_done(op_done),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  pll_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      step   <= '0;
      mult_q <= '0;
      div_q  <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          mult_q <= mult_in;
          div_q  <= div_in;
          step   <= '0;
          busy   <= 1'b1;
          state  <= S_ISSUE;
        end
        S_ISSUE: state <= S_AWAIT;
        S_AWAIT: if (op_done) begin
          if (step == STEP_LAST) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            step  <= step + 1'b1;
            state <= tmr_load ? S_WAIT : S_ISSUE;
          end
        end
        S_WAIT: if (tmr_exp) state <= S_ISSUE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R11
  done_end_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy && $past(busy));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> !bus_req);
  // R12
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(mult_q) && $stable(div_q));
  // R7
  wait_quiet_chk: assert property (@(posedge clk) disable iff (rst) (state == S_WAIT) |-> !bus_req);
endmodule

// File: tb/pll_bringup_seq_bench.sv
module pll_bringup_seq_bench;
  localparam int RST_W = 250;
  localparam int LUNIT = 500;
  localparam logic [7:0] A_ADR = 8'h00;
  localparam logic [7:0] B_ADR = 8'h04;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [12:0] mult_in = '0;
  logic [5:0]  div_in = '0;
  logic busy, done, bus_req, bus_we, bus_ready = 1'b0;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata = '0;

  always #10 clk = ~clk;

  pll_bringup_seq #(.ADDR_W(8), .CTL_A_ADDR(A_ADR), .CTL_B_ADDR(B_ADR),
                    .RST_WAIT_CYC(RST_W), .LOCK_UNIT(LUNIT)) u_pll_bringup_seq (
    .clk(clk), .rst(rst), .start(start), .mult_in(mult_in), .div_in(div_in),
    .busy(busy), .done(done), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  int nvec = 0, nbad = 0, cycles = 0;
  int txn = 0, gap = 0, lat = 0;
  bit seen = 0;
  logic [31:0] reg_a, reg_b;
  int exp_m, exp_d;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int bw_of(input int m);
    return (((m + 1) >> 1) - 1) & 32'hFFF;
  endfunction

  function automatic logic [7:0] addr_of(input int s);
    return (s == 1 || s == 4 || s == 5) ? B_ADR : A_ADR;
  endfunction

  function automatic int gap_of(input int s);
    if (s == 5) return RST_W + 3;
    if (s == 6) return LUNIT * (exp_d + 1) + 3;
    return 2;
  endfunction

  function automatic logic [31:0] wr_of(input int s, input logic [31:0] old);
    int bw = bw_of(exp_m);
    case (s)
      0: return old | (32'h1 << 23);
      1: return old | (32'h1 << 14);
      2: return (old & ~32'h0007_FFFF) | (32'(exp_m) << 6) | 32'(exp_d);
      3: return (old & ~32'hFF00_0000) | (32'(bw & 8'hFF) << 24);
      4: return (old & ~32'hF) | 32'(bw >> 8);
      5: return old & ~(32'h1 << 14);
      default: return old & ~(32'h1 << 23);
    endcase
  endfunction

  function automatic string tag_of(input int s);
    case (s)
      0, 1, 2: return "R5";
      3, 4: return "R6";
      5: return "R8";
      default: return "R10";
    endcase
  endfunction

  // register-bus slave model with random ready latency
  always @(negedge clk) begin
    if (rst) begin
      bus_ready = 1'b0; seen = 0; gap = 0;
    end else begin
      if (bus_ready) begin bus_ready = 1'b0; lat = $urandom % 4; end
      if (!bus_req) gap++;
      else if (!bus_ready) begin
        if (!seen) begin
          seen = 1;
          check(txn < 14, "R10 extra request", 32'(txn), 32'd13);
          if (txn < 14) begin
            check(bus_we == txn[0], "R2 read/write order", 32'(bus_we), 32'(txn[0]));
            check(bus_addr == addr_of(txn / 2), "R2 address", 32'(bus_addr), 32'(addr_of(txn / 2)));
            if (!txn[0] && txn > 0) begin
              if (txn / 2 == 5)      check(gap == gap_of(5), "R7 reset wait", 32'(gap), 32'(gap_of(5)));
              else if (txn / 2 == 6) check(gap == gap_of(6), "R9 lock wait", 32'(gap), 32'(gap_of(6)));
              else                   check(gap == 2, "R13 step gap", 32'(gap), 32'd2);
            end
          end
        end
        if (lat == 0) begin
          if (!bus_we) bus_rdata = (bus_addr == B_ADR) ? reg_b : reg_a;
          else if (txn < 14) begin
            logic [31:0] old, ex;
            old = (bus_addr == B_ADR) ? reg_b : reg_a;
            ex  = wr_of(txn / 2, old);
            check(bus_wdata == ex, {tag_of(txn / 2), " R4 write data"}, bus_wdata, ex);
            if (bus_addr == B_ADR) reg_b = bus_wdata; else reg_a = bus_wdata;
          end
          txn++;
          gap = 0;
          seen = 0;
          bus_ready = 1'b1;
        end else lat--;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      nbad++;
      $display("FAIL watchdog act=%0d exp=done", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  task automatic run(input int m, input int d, input bit inject);
    exp_m = m; exp_d = d;
    reg_a = $urandom; reg_b = $urandom;
    txn = 0; gap = 0;
    @(negedge clk);
    mult_in = 13'(m); div_in = 6'(d); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R11 busy rises", 32'(busy), 32'd1);
    if (inject) begin
      wait (txn >= 5);
      @(negedge clk);
      mult_in = ~13'(m); div_in = 6'(d + 1); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (txn == 14);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b1, "R11 done early", {busy, done}, 32'b10);
    @(negedge clk);
    check(done == 1'b1 && busy == 1'b0, "R11 done timing", {busy, done}, 32'b01);
    @(negedge clk);
    check(done == 1'b0, "R11 done one cycle", 32'(done), 32'd0);
    check(reg_a[23] == 1'b0 && reg_b[14] == 1'b0, "R8 R10 final bits", {reg_a[23], reg_b[14]}, 32'd0);
    check(reg_a[18:6] == 13'(m) && reg_a[5:0] == 6'(d), "R12 latched fields", reg_a, 32'(m));
    repeat (12) begin
      @(negedge clk);
      if (bus_req || done) check(1'b0, "R12 R10 idle after run", {bus_req, done}, 32'd0);
    end
    check(txn == 14, "R2 transfer count", 32'(txn), 32'd14);
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !bus_req, "R1 reset state", {busy, done, bus_req}, 32'd0);
    repeat (5) @(negedge clk);
    check(!bus_req && !busy, "R1 stays idle", {bus_req, busy}, 32'd0);
    run(0, 0, 1'b0);
    run(8191, 63, 1'b1);
    run(1, 1, 1'b0);
    run(2, 2, 1'b1);
    for (int i = 0; i < 6; i++) run(int'($urandom % 8192), int'($urandom % 8), i[0]);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule